// File: doc/BRIEF.md
# Priority-Threshold Packet Admission Queue

This block is the receive queue of a packet endpoint. It holds up to eight whole packets, described by their 2-bit priority and payload length. As each packet arrives, the block looks at how full the queue is and compares that with a limit kept for the packet's priority. It then either stores the packet or answers with a retry. Low-priority packets get a smaller limit than high-priority ones. As the buffer fills, the block refuses low-priority traffic first, and keeps the last slots for the most urgent packets.

Stored packets leave in arrival order through a dequeue port toward the logical layer. When a packet is taken in the same cycle that a new one arrives, the slot it frees counts before the admission comparison is made.

A separate path handles outgoing responses. It takes the priority of the request that a response answers, adds one, holds the result at the top level 3, and presents it one cycle later.

Top module: `pkt_admit_queue`

## Requirements
- R1: After a synchronous active-high reset, `occupancy` is 0, `deq_valid` is 0, and `adm_accept`, `adm_retry` and `rsp_valid` are 0.
- R2: A priority-0 packet with a valid length is accepted when the effective occupancy is 4 or less, and is retried when it is above 4.
- R3: A packet with a valid length and priority 1, 2 or 3 is accepted when the effective occupancy is at most 5, 6 or 7 respectively, and is retried otherwise. Priority 3 can therefore fill all eight slots.
- R4: A retried packet leaves the stored contents and the occupancy unchanged, apart from any simultaneous dequeue.
- R5: Packets leave in arrival order. While `deq_valid` is 1, `deq_prio` and `deq_len` show the oldest stored packet. A dequeue happens on a clock edge where `deq_ready` and `deq_valid` are both 1.
- R6: The effective occupancy is `occupancy` minus one when a dequeue happens in the same cycle as the arrival, and `occupancy` otherwise.
- R7: A packet whose length is 0, or greater than the 256-byte maximum payload, is retried whatever its priority and the occupancy.
- R8: One cycle after `rsp_in_valid` is 1, `rsp_valid` is 1 and `rsp_prio` equals the input priority plus one, held at 3 (3 maps to 3, never to 0).
- R9: `deq_ready` while the queue is empty has no effect: `occupancy` stays 0 and no packet appears.
- R10: `adm_accept` and `adm_retry` are registered one-cycle pulses. Exactly one of them is 1 in the cycle after each arrival, and both are 0 after a cycle with no arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | A packet arrives this cycle |
| arr_prio | input | 2 | Priority of the arriving packet |
| arr_len | input | 9 | Payload length in bytes of the arriving packet |
| adm_accept | output | 1 | Pulse: the previous cycle's packet was stored |
| adm_retry | output | 1 | Pulse: the previous cycle's packet was refused |
| deq_ready | input | 1 | Logical layer takes the head packet |
| deq_valid | output | 1 | The queue holds at least one packet |
| deq_prio | output | 2 | Priority of the head packet |
| deq_len | output | 9 | Length of the head packet |
| occupancy | output | 4 | Number of stored packets |
| rsp_in_valid | input | 1 | A response is being created for a request |
| rsp_in_prio | input | 2 | Priority of that request |
| rsp_valid | output | 1 | Promoted response priority is valid |
| rsp_prio | output | 2 | Response priority (request plus one, held at 3) |

## Verification
The bench runs the queue at exactly 4, 5, 6 and 7 stored packets with each priority. A design that is off by one on a threshold would accept one packet too many or refuse one too early.

It also makes packets arrive while a dequeue happens at those boundaries and at full. A design that compares against the stale count would retry packets that the freed slot should have admitted.

Lengths of 0, 256 and 257 confirm that only the out-of-range values are refused. Priority 3 on the response path checks that promotion holds at 3 rather than wrapping to 0. Dequeue requests on an empty queue must leave the count at zero instead of underflowing.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef logic [1:0] prio_t;

  // one level up, held at the top level
  function automatic prio_t promote(input prio_t p);
    return (p == 2'd3) ? 2'd3 : p + 2'd1;
  endfunction
endpackage

// File: rtl/adm_thresh_regs.sv
module adm_thresh_regs #(
  parameter int          NPRIO    = 4,
  parameter int          CNT_W    = 4,
  parameter logic [15:0] THR_INIT = 16'h7654
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [NPRIO*CNT_W-1:0] thr_flat
);
  localparam int FLD_W = 16 / NPRIO;

  for (genvar p = 0; p < NPRIO; p++) begin : g_thr
    logic [CNT_W-1:0] thr_q;
    always_ff @(posedge clk) begin
      if (rst) thr_q <= CNT_W'(THR_INIT[p*FLD_W +: FLD_W]);
    end
    assign thr_flat[p*CNT_W +: CNT_W] = thr_q;
  end
endmodule

// File: rtl/adm_decide.sv
module adm_decide #(
  parameter int NPRIO   = 4,
  parameter int CNT_W   = 4,
  parameter int LEN_W   = 9,
  parameter int MAX_LEN = 256
) (
  input  logic                   arr_valid,
  input  logic [1:0]             arr_prio,
  input  logic [LEN_W-1:0]       arr_len,
  input  logic [CNT_W-1:0]       count,
  input  logic                   pop,
  input  logic [NPRIO*CNT_W-1:0] thr_flat,
  output logic                   take,
  output logic                   refuse
);
  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] limit;
  logic             len_ok;

  always_comb begin
    eff    = count - CNT_W'(pop);
    limit  = thr_flat[arr_prio*CNT_W +: CNT_W];
    len_ok = (arr_len != '0) && (arr_len <= LEN_W'(MAX_LEN));
    take   = arr_valid && len_ok && (eff <= limit);
    refuse = arr_valid && !take;
  end
endmodule

// File: rtl/pkt_desc_fifo.sv
module pkt_desc_fifo #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 9,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [1:0]       push_prio,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [1:0]       head_prio,
  output logic [LEN_W-1:0] head_len,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = LEN_W + 2;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_prio, push_len};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign {head_prio, head_len} = mem[rd_ptr];
endmodule

// File: rtl/rsp_promote.sv
module rsp_promote (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [1:0] in_prio,
  output logic       out_valid,
  output logic [1:0] out_prio
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prio  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_prio <= adm_pkg::promote(in_prio);
    end
  end
endmodule

// File: rtl/pkt_admit_queue.sv
module pkt_admit_queue #(
  parameter int          DEPTH    = 8,
  parameter int          LEN_W    = 9,
  parameter int          MAX_LEN  = 256,
  parameter logic [15:0] THR_INIT = 16'h7654,
  localparam int         CNT_W    = $clog2(DEPTH + 1),
  localparam int         NPRIO    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arr_valid,
  input  logic [1:0]       arr_prio,
  input  logic [LEN_W-1:0] arr_len,
  output logic             adm_accept,
  output logic             adm_retry,
  input  logic             deq_ready,
  output logic             deq_valid,
  output logic [1:0]       deq_prio,
  output logic [LEN_W-1:0] deq_len,
  output logic [CNT_W-1:0] occupancy,
  input  logic             rsp_in_valid,
  input  logic [1:0]       rsp_in_prio,
  output logic             rsp_valid,
  output logic [1:0]       rsp_prio
);
  logic [NPRIO*CNT_W-1:0] thr_flat;
  logic                   pop, take, refuse;

  assign deq_valid = (occupancy != '0);
  assign pop       = deq_ready && deq_valid;

  adm_thresh_regs #(.NPRIO(NPRIO), .CNT_W(CNT_W), .THR_INIT(THR_INIT)) u_thr (
    .clk(clk), .rst(rst), .thr_flat(thr_flat)
  );

  adm_decide #(.NPRIO(NPRIO), .CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_dec (
    .arr_valid(arr_valid), .arr_prio(arr_prio), .arr_len(arr_len),
    .count(occupancy), .pop(pop), .thr_flat(thr_flat),
    .take(take), .refuse(refuse)
  );

  pkt_desc_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst(rst), .push(take), .push_prio(arr_prio), .push_len(arr_len),
    .pop(pop), .head_prio(deq_prio), .head_len(deq_len), .count(occupancy)
  );

  rsp_promote u_rsp (
    .clk(clk), .rst(rst), .in_valid(rsp_in_valid), .in_prio(rsp_in_prio),
    .out_valid(rsp_valid), .out_prio(rsp_prio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      adm_accept <= 1'b0;
      adm_retry  <= 1'b0;
    end else begin
      adm_accept <= take;
      adm_retry  <= refuse;
    end
  end
endmodule

// File: rtl/adm_checker.sv
module adm_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             arr_valid,
  input logic [1:0]       arr_prio,
  input logic             adm_accept,
  input logic             adm_retry,
  input logic             deq_ready,
  input logic             deq_valid,
  input logic [CNT_W-1:0] occupancy,
  input logic             rsp_in_valid,
  input logic [1:0]       rsp_in_prio,
  input logic             rsp_valid,
  input logic [1:0]       rsp_prio
);
  logic pop_c;
  assign pop_c = deq_ready && deq_valid;

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({adm_accept, adm_retry}));

  // R10
  result_follows_arrival_chk: assert property (@(posedge clk) disable iff (rst)
    arr_valid |=> (adm_accept || adm_retry));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy <= CNT_W'(DEPTH));

  // R4
  retry_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_valid && !rsp_in_valid && pop_c) |=> (adm_retry -> (occupancy == $past(occupancy) - 1'b1)));

  // R4
  retry_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_valid && !pop_c) |=> (adm_retry -> (occupancy == $past(occupancy))));

  // R2
  prio0_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_valid && arr_prio == 2'd0 && (occupancy - CNT_W'(pop_c)) > CNT_W'(4)) |=> adm_retry);

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (occupancy == '0 && !arr_valid) |=> (occupancy == '0));

  // R8
  promote_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_in_valid |=> (rsp_valid && rsp_prio == (($past(rsp_in_prio) == 2'd3) ? 2'd3 : $past(rsp_in_prio) + 2'd1)));
endmodule

bind pkt_admit_queue adm_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_prio(arr_prio),
  .adm_accept(adm_accept), .adm_retry(adm_retry), .deq_ready(deq_ready),
  .deq_valid(deq_valid), .occupancy(occupancy), .rsp_in_valid(rsp_in_valid),
  .rsp_in_prio(rsp_in_prio), .rsp_valid(rsp_valid), .rsp_prio(rsp_prio)
);

// File: tb/sim_pkt_admit_queue.sv
`timescale 1ns/1ps
module sim_pkt_admit_queue;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 0, rst = 1;
  logic       arr_valid = 0, deq_ready = 0, rsp_in_valid = 0;
  logic [1:0] arr_prio = 0, rsp_in_prio = 0;
  logic [8:0] arr_len = 0;
  logic       adm_accept, adm_retry, deq_valid, rsp_valid;
  logic [1:0] deq_prio, rsp_prio;
  logic [8:0] deq_len;
  logic [3:0] occupancy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_admit_queue u0 (
    .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_prio(arr_prio), .arr_len(arr_len),
    .adm_accept(adm_accept), .adm_retry(adm_retry), .deq_ready(deq_ready),
    .deq_valid(deq_valid), .deq_prio(deq_prio), .deq_len(deq_len), .occupancy(occupancy),
    .rsp_in_valid(rsp_in_valid), .rsp_in_prio(rsp_in_prio),
    .rsp_valid(rsp_valid), .rsp_prio(rsp_prio)
  );

  int checks = 0, fails = 0;
  int mprio [8];
  int mlen  [8];
  int mcnt  = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int limit_of(input int p);
    return 4 + p;
  endfunction

  function automatic bit exp_take(input int p, input int len, input int cnt, input bit pop);
    int eff = cnt - (pop ? 1 : 0);
    return (len >= 1) && (len <= 256) && (eff <= limit_of(p));
  endfunction

  function automatic int promote(input int p);
    return (p == 3) ? 3 : p + 1;
  endfunction

  // one clock: drive at negedge, compare after the edge
  task automatic step(input bit av, input int p, input int len, input bit dr);
    bit pop, tk;
    @(negedge clk);
    if (mcnt > 0) begin
      check(deq_valid == 1, "R5 head valid", deq_valid, 1);
      check(deq_prio == mprio[0] && deq_len == mlen[0], "R5 head order",
            {deq_prio, deq_len}, {mprio[0][1:0], mlen[0][8:0]});
    end else begin
      check(deq_valid == 0, "R9 empty valid", deq_valid, 0);
    end
    arr_valid = av; arr_prio = p[1:0]; arr_len = len[8:0]; deq_ready = dr;
    pop = dr && (mcnt > 0);
    tk  = av && exp_take(p, len, mcnt, pop);
    @(posedge clk); #1;
    if (pop) begin
      for (int i = 0; i < 7; i++) begin mprio[i] = mprio[i+1]; mlen[i] = mlen[i+1]; end
      mcnt--;
    end
    if (tk) begin mprio[mcnt] = p; mlen[mcnt] = len; mcnt++; end
    if (!av)
      check(!adm_accept && !adm_retry, "R10 idle flags", {adm_accept, adm_retry}, 0);
    else if (len < 1 || len > 256)
      check(adm_retry && !adm_accept, "R7 bad length", {adm_accept, adm_retry}, 1);
    else if (pop)
      check(adm_accept == tk && adm_retry == !tk, "R6 pop then compare", {adm_accept, adm_retry}, {tk, !tk});
    else if (p == 0)
      check(adm_accept == tk && adm_retry == !tk, "R2 prio0 limit", {adm_accept, adm_retry}, {tk, !tk});
    else
      check(adm_accept == tk && adm_retry == !tk, "R3 prio limit", {adm_accept, adm_retry}, {tk, !tk});
    check(occupancy == mcnt, (av && !tk) ? "R4 retry state" : "R5 count", occupancy, mcnt);
    arr_valid = 0; deq_ready = 0;
  endtask

  task automatic fill_to(input int n);
    while (mcnt > n) step(0, 0, 1, 1);
    while (mcnt < n) step(1, 3, 1 + mcnt, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd13));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check(occupancy == 0 && !deq_valid && !adm_accept && !adm_retry && !rsp_valid,
          "R1 reset", {occupancy, deq_valid, adm_accept, adm_retry, rsp_valid}, 0);

    // R9: dequeue on empty
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);

    // R2 / R3: each priority at and just past its limit
    for (int p = 0; p < 4; p++) begin
      fill_to(limit_of(p));
      step(1, p, 100, 0);                       // accepted at limit
      if (p < 3) step(1, p, 101, 0);            // now above: retried
      else step(1, 3, 101, 0);                  // full: retried
      step(1, p, 102, 1);                       // R6: pop frees a slot
    end

    // R7: length boundaries
    fill_to(0);
    step(1, 2, 0, 0);
    step(1, 2, 257, 0);
    step(1, 2, 256, 0);
    step(1, 2, 511, 0);

    // R5: drain in order
    fill_to(3);
    step(0, 0, 1, 1); step(0, 0, 1, 1); step(0, 0, 1, 1); step(0, 0, 1, 1);

    // R8: response promotion, all priorities
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); rsp_in_valid = 1; rsp_in_prio = p[1:0];
      @(posedge clk); #1;
      check(rsp_valid && rsp_prio == promote(p), "R8 promote", {rsp_valid, rsp_prio}, {1'b1, promote(p)});
    end
    @(negedge clk); rsp_in_valid = 0;
    @(posedge clk); #1;
    check(!rsp_valid, "R8 idle", rsp_valid, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      int l = ($urandom_range(0, 19) == 0) ? $urandom_range(257, 511) * $urandom_range(0, 1)
                                           : $urandom_range(1, 256);
      step(r < 70, $urandom_range(0, 3), l, $urandom_range(0, 99) < 40);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule